// File: doc/BRIEF.md
# Binary-to-One-Hot Select Decoder

This block turns a compact binary select code into a bus of select lines in which exactly one line is high. It drives two buses at once: the true one-hot bus and its bitwise complement. Multiplexer stages built from complementary pass gates need both polarities of every select line. The block is purely combinational, so a change on the address reaches both buses in the same cycle with no register in the path.

The number of select lines `LINES` is the only parameter. The address width follows from it: it is the base-2 logarithm of `LINES`, rounded up, with a floor of one bit. When `LINES` is not a power of two, some address codes name no line. Those codes select the highest line rather than leaving the bus empty. When `LINES` is one, no decoding takes place: the single select line copies the address bit, and the complement line carries its inverse.

Top module: `onehot_sel_decoder`

## Requirements
- R1: The address port is ceil(log2(LINES)) bits wide, and exactly 1 bit wide when LINES is 1.
- R2: With LINES of at least 2, an address value i below LINES drives select line i high and every other select line low.
- R3: With LINES of at least 2, an address value of LINES or more drives only select line LINES-1 high.
- R4: The complement bus equals the bitwise inverse of the select bus for every address value.
- R5: With LINES of at least 2, exactly one select line is high for every address value, including unused codes.
- R6: With LINES equal to 1, the select line equals the address bit and the complement line equals its inverse.
- R7: Both buses follow a change of address within the same clock cycle, with no register latency.
- R8: A LINES value of 0 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_addr | input | AW = max(1, ceil(log2(LINES))) | Binary select code |
| sel_line | output | LINES | One-hot select bus, line i is bit i |
| sel_line_n | output | LINES | Bitwise complement of sel_line |

## Verification
The block holds no state. A fault in the range clamp, the comparator bank or the inverter bank therefore appears on the ports in the same cycle as the address that exposes it. A bad comparator shows as a wrong or missing high line. A bad clamp shows as an empty bus or a wrong line on the unused codes only. A bad inverter shows as a bit on which the two buses agree. A full sweep of every address code reaches every such fault. The sweep runs on three configurations: a size that is not a power of two, a power-of-two size, and the single-line case.

// File: rtl/sel_dec_pkg.sv
package sel_dec_pkg;

   // Address width needed to name every select line, never less than one bit.
   function automatic int unsigned addr_width(input int unsigned lines);
      int unsigned w;
      w = 1;
      while ((1 << w) < lines) w++;
      return w;
   endfunction

endpackage

// File: rtl/sel_dec_range.sv
// Clamps an address code to a valid line index: codes past the last line
// collapse onto the last line.
module sel_dec_range #(
   parameter int unsigned LINES = 6,
   parameter int unsigned AW    = sel_dec_pkg::addr_width(LINES)
) (
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] idx
);
   localparam int unsigned SPAN = 1 << AW;

   generate
      if (LINES == SPAN) begin : g_full
         // Every code names a line; nothing to clamp.
         assign idx = addr;
      end else begin : g_clamp
         localparam logic [AW:0]   LIMIT = (AW+1)'(LINES);
         localparam logic [AW-1:0] TOP   = AW'(LINES - 1);
         logic over;
         assign over = {1'b0, addr} >= LIMIT;
         assign idx  = over ? TOP : addr;
      end
   endgenerate
endmodule

// File: rtl/sel_dec_onehot.sv
// One equality comparator per select line.
module sel_dec_onehot #(
   parameter int unsigned LINES = 6,
   parameter int unsigned AW    = sel_dec_pkg::addr_width(LINES)
) (
   input  logic [AW-1:0]    idx,
   output logic [LINES-1:0] line
);
   generate
      for (genvar k = 0; k < LINES; k++) begin : g_cmp
         assign line[k] = (idx == AW'(k));
      end
   endgenerate
endmodule

// File: rtl/sel_dec_compl.sv
// Inverter bank producing the complementary select polarity.
module sel_dec_compl #(
   parameter int unsigned LINES = 6
) (
   input  logic [LINES-1:0] line,
   output logic [LINES-1:0] line_n
);
   generate
      for (genvar k = 0; k < LINES; k++) begin : g_inv
         assign line_n[k] = ~line[k];
      end
   endgenerate
endmodule

// File: rtl/onehot_sel_decoder.sv
module onehot_sel_decoder #(
   parameter  int unsigned LINES = 6,
   localparam int unsigned AW    = sel_dec_pkg::addr_width(LINES)
) (
   input  logic [AW-1:0]    sel_addr,
   output logic [LINES-1:0] sel_line,
   output logic [LINES-1:0] sel_line_n
);
   // R8: a zero-line decoder is meaningless.
   generate
      if (LINES < 1) begin : g_bad_lines
         $error("onehot_sel_decoder: LINES must be at least 1");
      end
      // R1: the address must name every line and be no wider than needed.
      if ((1 << AW) < LINES || (AW > 1 && (1 << (AW - 1)) >= LINES)) begin : g_bad_aw
         $error("onehot_sel_decoder: address width inconsistent with LINES");
      end
   endgenerate

   generate
      if (LINES == 1) begin : g_single
         // R6: degenerate case, the address bit is the select line.
         assign sel_line   = sel_addr;
         assign sel_line_n = ~sel_addr;

         always_comb begin
            assert_single_pass_R6: assert (sel_line == sel_addr);
            assert_single_compl_R4: assert (sel_line_n != sel_line);
         end
      end else begin : g_multi
         logic [AW-1:0] idx;

         sel_dec_range #(.LINES(LINES), .AW(AW)) range_i (
            .addr (sel_addr),
            .idx  (idx)
         );

         sel_dec_onehot #(.LINES(LINES), .AW(AW)) onehot_i (
            .idx  (idx),
            .line (sel_line)
         );

         sel_dec_compl #(.LINES(LINES)) compl_i (
            .line   (sel_line),
            .line_n (sel_line_n)
         );

         always_comb begin
            assert_exactly_one_R5: assert ($onehot(sel_line));
            assert_compl_bus_R4: assert ((sel_line ^ sel_line_n) == {LINES{1'b1}});
            if ({1'b0, sel_addr} >= (AW+1)'(LINES)) begin
               assert_fallback_top_R3: assert (sel_line[LINES-1]);
            end else begin
               assert_selected_bit_R2: assert (sel_line[sel_addr]);
            end
         end
      end
   endgenerate
endmodule

// File: tb/onehot_sel_decoder_tb.sv
module onehot_sel_decoder_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk; // 250 MHz

   logic [2:0] addr_a = '0;  // LINES = 6
   logic [0:0] addr_b = '0;  // LINES = 1
   logic [2:0] addr_c = '0;  // LINES = 8
   logic [5:0] line_a, line_a_n;
   logic [0:0] line_b, line_b_n;
   logic [7:0] line_c, line_c_n;

   onehot_sel_decoder #(.LINES(6)) dut_i (
      .sel_addr(addr_a), .sel_line(line_a), .sel_line_n(line_a_n));
   onehot_sel_decoder #(.LINES(1)) dut_one_i (
      .sel_addr(addr_b), .sel_line(line_b), .sel_line_n(line_b_n));
   onehot_sel_decoder #(.LINES(8)) dut_pow_i (
      .sel_addr(addr_c), .sel_line(line_c), .sel_line_n(line_c_n));

   typedef struct {
      int unsigned which;
      int unsigned code;
      logic [7:0]  exp;
      string       req;
   } item_t;

   item_t sb_q[$];
   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic int unsigned lines_of(input int unsigned which);
      return (which == 0) ? 6 : (which == 1) ? 1 : 8;
   endfunction

   // Driver: applies a code one cycle at a time and pushes the expectation.
   task automatic drive(input int unsigned which, input int unsigned code, input string req);
      item_t it;
      int unsigned n;
      n = lines_of(which);
      @(posedge clk);
      #1;
      case (which)
         0: addr_a = 3'(code);
         1: addr_b = 1'(code);
         default: addr_c = 3'(code);
      endcase
      it.which = which;
      it.code  = code;
      if (n == 1) it.exp = 8'(code & 1);
      else if (code < n) it.exp = 8'(1 << code);
      else it.exp = 8'(1 << (n - 1));
      it.req = req;
      sb_q.push_back(it);
   endtask

   // Monitor: same cycle as the drive (R7: no latency), sampled on negedge.
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] d, dn, mask;
            int unsigned n;
            it = sb_q.pop_front();
            n = lines_of(it.which);
            mask = 8'((1 << n) - 1);
            case (it.which)
               0: begin d = 8'(line_a); dn = 8'(line_a_n); end
               1: begin d = 8'(line_b); dn = 8'(line_b_n); end
               default: begin d = line_c; dn = line_c_n; end
            endcase
            check($sformatf("%s/R7 n=%0d code=%0d data", it.req, n, it.code), d, it.exp);
            check($sformatf("R4 n=%0d code=%0d inverted", n, it.code), dn & mask, ~it.exp & mask);
            if (n > 1)
               check($sformatf("R5 n=%0d code=%0d ones", n, it.code), 8'($countones(d)), 8'd1);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Initial state: address 0 selects line 0 (R2), single-line case gives 0 (R6).
      check("R2 initial", 8'(line_a), 8'b0000_0001);
      check("R6 initial", 8'(line_b), 8'd0);
      // R1: port widths
      check("R1 width n=6", 8'($bits(addr_a)), 8'd3);
      check("R1 width n=1", 8'($bits(dut_one_i.sel_addr)), 8'd1);
      check("R1 width n=8", 8'($bits(dut_pow_i.sel_addr)), 8'd3);
      for (int c = 0; c < 8; c++) drive(0, c, (c < 6) ? "R2" : "R3");
      for (int c = 0; c < 2; c++) drive(1, c, "R6");
      for (int c = 7; c >= 0; c--) drive(2, c, "R2");
      // Jumps between an unused code and a valid one (R3 then R2).
      drive(0, 7, "R3");
      drive(0, 0, "R2");
      drive(0, 6, "R3");
      drive(0, 5, "R2");
      drive(1, 0, "R6");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule